// File: doc/BRIEF.md
# Address Translation Request Front End

This block is the entry stage of an address translation unit. It takes one request at a time. A request is an effective address, an access type and three machine-state bits: problem state, instruction relocate and data relocate. The block first decides whether the access runs in real mode. In real mode it answers at once with a real address and full permissions. Otherwise it works out the partition and process identifiers from the address quadrant and checks the process identifier against the size of the process table. If the identifier is in range, it reads the 64-bit process table entry over a valid/ready memory read port. It then starts the radix walker with the root directory base, the root size and the address-space size taken from that entry. An illegal quadrant or an out-of-range process identifier is reported as a fault in place of a walk.

The controller has four states. `ST_IDLE` accepts a request (`req_ready` high). In that same cycle it picks the outcome and moves to `ST_REPORT` for a bypass or a fault, or to `ST_RD_REQ` for a walk. `ST_RD_REQ` holds the table read request until `mem_req_ready`, then moves to `ST_RD_WAIT`. `ST_RD_WAIT` waits for `mem_rsp_valid`, keeps the entry and moves to `ST_REPORT`. `ST_REPORT` drives exactly one result pulse for one cycle and returns to `ST_IDLE`. The configuration inputs are sampled in the cycle the request is accepted.

Top module: `xlat_front_end`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `busy`=0, and `res_valid`, `fault_valid`, `walk_start` and `mem_req_valid` are all 0.
- R2: Translation mode is chosen per access type, with `req_acc` encoded as 0 = read, 1 = write, 2 = fetch (3 is handled as a read). A fetch bypasses when `req_ir`=0. A read or write bypasses when `req_dr`=0. The other relocate bit has no effect.
- R3: A bypass produces `res_valid` in the cycle after acceptance. In that cycle `res_raddr` is the effective address with bits 63:60 cleared, and `res_perm`=3'b111 (bit 0 read, bit 1 write, bit 2 execute).
- R4: The quadrant is effective-address bits 63:62. Quadrant 0 uses `cfg_lpid` and `cfg_pid`. Quadrant 3 uses `cfg_lpid` with process identifier 0.
- R5: Quadrants 1 and 2 give a segment fault (`fault_seg`=1, `fault_cause`=0) in the cycle after acceptance. `fault_instr` is 1 for a fetch and 0 otherwise. `fault_addr` is the effective address for data faults and 0 for fetch faults.
- R6: The table holds 2^(`cfg_tbl_log`+12) bytes of 16-byte entries. A process identifier whose offset (identifier × 16) is at or beyond that size gives a storage fault (`fault_seg`=0, cause bit 0 "no translation") in the cycle after acceptance, and no memory read is made.
- R7: In a storage fault, a write also sets cause bit 4 ("is store"). A fetch gives `fault_instr`=1 and `fault_addr`=0. A read or write gives `fault_instr`=0 and `fault_addr` equal to the effective address. Cause bits 1 to 3 (protection, bad configuration, guarded execute) are never set by this block.
- R8: For a walk, `mem_req_valid` rises in the cycle after acceptance with `mem_req_addr` = `cfg_tbl_base` + identifier × 16. Address and valid hold until `mem_req_ready`.
- R9: `walk_start` pulses in the cycle after the `mem_rsp_valid` edge. It carries `walk_root_base` = {entry[59:8], 8'b0}, `walk_root_size` = entry[4:0], `walk_as_size` = {entry[62:61], entry[7:5]} + 31, and the request's address, access type, problem-state bit, partition and process identifiers.
- R10: `busy` is high from acceptance through the result cycle, and requests are not accepted meanwhile. Each request gives exactly one of `res_valid`, `fault_valid` or `walk_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_ea | input | 64 | Effective address |
| req_acc | input | 2 | Access type (0 read, 1 write, 2 fetch) |
| req_pr | input | 1 | Problem-state bit, passed to the walker |
| req_ir | input | 1 | Instruction relocate enable |
| req_dr | input | 1 | Data relocate enable |
| cfg_lpid | input | 12 | Current partition identifier |
| cfg_pid | input | 20 | Current process identifier |
| cfg_tbl_base | input | 64 | Process table base address |
| cfg_tbl_log | input | 5 | Table size exponent (size = 2^(n+12) bytes) |
| busy | output | 1 | Request in progress |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Table entry address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Table entry |
| res_valid | output | 1 | Bypass result pulse |
| res_raddr | output | 64 | Real address of bypass |
| res_perm | output | 3 | Permissions {x, w, r} |
| fault_valid | output | 1 | Fault pulse |
| fault_seg | output | 1 | 1 segment fault, 0 storage fault |
| fault_instr | output | 1 | 1 instruction-type, 0 data-type |
| fault_cause | output | 5 | One-hot cause flags |
| fault_addr | output | 64 | Faulting address (data faults) |
| walk_start | output | 1 | Walk start pulse |
| walk_ea | output | 64 | Address to translate |
| walk_acc | output | 2 | Access type |
| walk_pr | output | 1 | Problem-state bit |
| walk_lpid | output | 12 | Partition identifier |
| walk_pid | output | 20 | Process identifier |
| walk_root_base | output | 64 | Root directory base |
| walk_root_size | output | 5 | Root directory index width |
| walk_as_size | output | 6 | Address-space size exponent |

## Verification
Bypass results and both fault kinds appear exactly one cycle after the acceptance edge. The table read request appears in that same cycle. `walk_start` appears one cycle after the edge that carries `mem_rsp_valid`. The bench drives on the falling edge. It samples at the first falling edge after each such rising edge and requires the pulse there and nowhere else. During random stalls on the read port and random response delays, it also checks that the request is held steady, that `busy` stays high and that no result pulse appears early.

// File: rtl/xlf_pkg.sv
package xlf_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_REPORT
    } state_e;

    typedef enum logic [1:0] {
        OUT_BYPASS,
        OUT_SEG,
        OUT_STOR,
        OUT_WALK
    } outcome_e;

    localparam int CAUSE_W    = 5;
    localparam int CB_NOTRANS = 0;
    localparam int CB_PROT    = 1;
    localparam int CB_BADCFG  = 2;
    localparam int CB_GUARD   = 3;
    localparam int CB_STORE   = 4;
endpackage

// File: rtl/xlf_mode_sel.sv
module xlf_mode_sel
    import xlf_pkg::*;
#(
    parameter int PID_W  = 20,
    parameter int LPID_W = 12
) (
    input  logic [1:0]        quad,
    input  logic [1:0]        acc,
    input  logic              ir,
    input  logic              dr,
    input  logic [LPID_W-1:0] cur_lpid,
    input  logic [PID_W-1:0]  cur_pid,
    output logic              is_fetch,
    output logic              bypass,
    output logic              quad_bad,
    output logic [LPID_W-1:0] sel_lpid,
    output logic [PID_W-1:0]  sel_pid
);
    always_comb begin
        is_fetch = (acc == ACC_FETCH);
        bypass   = is_fetch ? !ir : !dr;
        quad_bad = (quad == 2'd1) || (quad == 2'd2);
        sel_lpid = cur_lpid;
        sel_pid  = (quad == 2'd0) ? cur_pid : '0;
    end
endmodule

// File: rtl/xlf_tbl_index.sv
module xlf_tbl_index #(
    parameter int ADDR_W   = 64,
    parameter int PID_W    = 20,
    parameter int LOG_W    = 5,
    parameter int ENT_LOG2 = 4,
    parameter int MIN_LOG2 = 12
) (
    input  logic [PID_W-1:0]  pid,
    input  logic [LOG_W-1:0]  tbl_log,
    input  logic [ADDR_W-1:0] tbl_base,
    output logic              out_of_range,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int SH_W = LOG_W + 2;
    localparam logic [SH_W-1:0] IDX_BIAS = SH_W'(MIN_LOG2 - ENT_LOG2);

    logic [SH_W-1:0] idx_bits;

    always_comb begin
        idx_bits     = SH_W'(tbl_log) + IDX_BIAS;
        out_of_range = (pid >> idx_bits) != '0;
        entry_addr   = tbl_base + (ADDR_W'(pid) << ENT_LOG2);
    end
endmodule

// File: rtl/xlf_fault_fmt.sv
module xlf_fault_fmt
    import xlf_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic               is_seg,
    input  logic               is_fetch,
    input  logic               is_write,
    input  logic [ADDR_W-1:0]  ea,
    output logic               instr_type,
    output logic [CAUSE_W-1:0] cause,
    output logic [ADDR_W-1:0]  addr
);
    always_comb begin
        cause      = '0;
        instr_type = is_fetch;
        addr       = is_fetch ? '0 : ea;
        if (!is_seg) begin
            cause[CB_NOTRANS] = 1'b1;
            cause[CB_STORE]   = is_write && !is_fetch;
        end
    end
endmodule

// File: rtl/xlat_front_end.sv
module xlat_front_end
    import xlf_pkg::*;
#(
    parameter int EA_W     = 64,
    parameter int PID_W    = 20,
    parameter int LPID_W   = 12,
    parameter int LOG_W    = 5,
    parameter int CLR_BITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [EA_W-1:0]     req_ea,
    input  logic [1:0]          req_acc,
    input  logic                req_pr,
    input  logic                req_ir,
    input  logic                req_dr,
    input  logic [LPID_W-1:0]   cfg_lpid,
    input  logic [PID_W-1:0]    cfg_pid,
    input  logic [EA_W-1:0]     cfg_tbl_base,
    input  logic [LOG_W-1:0]    cfg_tbl_log,
    output logic                busy,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [EA_W-1:0]     mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [63:0]         mem_rsp_data,
    output logic                res_valid,
    output logic [EA_W-1:0]     res_raddr,
    output logic [2:0]          res_perm,
    output logic                fault_valid,
    output logic                fault_seg,
    output logic                fault_instr,
    output logic [CAUSE_W-1:0]  fault_cause,
    output logic [EA_W-1:0]     fault_addr,
    output logic                walk_start,
    output logic [EA_W-1:0]     walk_ea,
    output logic [1:0]          walk_acc,
    output logic                walk_pr,
    output logic [LPID_W-1:0]   walk_lpid,
    output logic [PID_W-1:0]    walk_pid,
    output logic [EA_W-1:0]     walk_root_base,
    output logic [4:0]          walk_root_size,
    output logic [5:0]          walk_as_size
);
    localparam logic [EA_W-1:0] KEEP_MASK = {EA_W{1'b1}} >> CLR_BITS;
    localparam logic [5:0]      AS_BIAS   = 6'd31;

    state_e   state_q, state_d;
    outcome_e outcome_q, outcome_d;

    logic [EA_W-1:0]   ea_q, addr_q;
    logic [1:0]        acc_q;
    logic              pr_q;
    logic [LPID_W-1:0] lpid_q;
    logic [PID_W-1:0]  pid_q;
    logic [1:0]        tsz_hi_q;
    logic [51:0]       root_q;
    logic [2:0]        tsz_lo_q;
    logic [4:0]        rsz_q;

    logic              is_fetch, bypass, quad_bad, oor;
    logic [LPID_W-1:0] sel_lpid;
    logic [PID_W-1:0]  sel_pid;
    logic [EA_W-1:0]   entry_addr;
    logic              accept;

    xlf_mode_sel #(.PID_W(PID_W), .LPID_W(LPID_W)) u_mode (
        .quad     (req_ea[EA_W-1 -: 2]),
        .acc      (req_acc),
        .ir       (req_ir),
        .dr       (req_dr),
        .cur_lpid (cfg_lpid),
        .cur_pid  (cfg_pid),
        .is_fetch (is_fetch),
        .bypass   (bypass),
        .quad_bad (quad_bad),
        .sel_lpid (sel_lpid),
        .sel_pid  (sel_pid)
    );

    xlf_tbl_index #(.ADDR_W(EA_W), .PID_W(PID_W), .LOG_W(LOG_W)) u_index (
        .pid          (sel_pid),
        .tbl_log      (cfg_tbl_log),
        .tbl_base     (cfg_tbl_base),
        .out_of_range (oor),
        .entry_addr   (entry_addr)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    // Outcome chosen in the accept cycle: bypass wins, then quadrant, then bound.
    always_comb begin
        if (bypass)        outcome_d = OUT_BYPASS;
        else if (quad_bad) outcome_d = OUT_SEG;
        else if (oor)      outcome_d = OUT_STOR;
        else               outcome_d = OUT_WALK;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid)
                            state_d = (outcome_d == OUT_WALK) ? ST_RD_REQ : ST_REPORT;
            ST_RD_REQ:  if (mem_req_ready) state_d = ST_RD_WAIT;
            ST_RD_WAIT: if (mem_rsp_valid) state_d = ST_REPORT;
            ST_REPORT:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outcome_q <= OUT_BYPASS;
            ea_q      <= '0;
            addr_q    <= '0;
            acc_q     <= '0;
            pr_q      <= 1'b0;
            lpid_q    <= '0;
            pid_q     <= '0;
            tsz_hi_q  <= '0;
            root_q    <= '0;
            tsz_lo_q  <= '0;
            rsz_q     <= '0;
        end else begin
            if (accept) begin
                outcome_q <= outcome_d;
                ea_q      <= req_ea;
                addr_q    <= entry_addr;
                acc_q     <= req_acc;
                pr_q      <= req_pr;
                lpid_q    <= sel_lpid;
                pid_q     <= sel_pid;
            end
            if (state_q == ST_RD_WAIT && mem_rsp_valid) begin
                tsz_hi_q <= mem_rsp_data[62:61];
                root_q   <= mem_rsp_data[59:8];
                tsz_lo_q <= mem_rsp_data[7:5];
                rsz_q    <= mem_rsp_data[4:0];
            end
        end
    end

    logic f_instr;
    logic [CAUSE_W-1:0] f_cause;
    logic [EA_W-1:0]    f_addr;

    xlf_fault_fmt #(.ADDR_W(EA_W)) u_fault (
        .is_seg     (outcome_q == OUT_SEG),
        .is_fetch   (acc_q == ACC_FETCH),
        .is_write   (acc_q == ACC_WRITE),
        .ea         (ea_q),
        .instr_type (f_instr),
        .cause      (f_cause),
        .addr       (f_addr)
    );

    always_comb begin
        req_ready      = (state_q == ST_IDLE);
        busy           = (state_q != ST_IDLE);
        mem_req_valid  = (state_q == ST_RD_REQ);
        mem_req_addr   = addr_q;
        res_valid      = (state_q == ST_REPORT) && (outcome_q == OUT_BYPASS);
        res_raddr      = ea_q & KEEP_MASK;
        res_perm       = 3'b111;
        fault_valid    = (state_q == ST_REPORT) &&
                         (outcome_q == OUT_SEG || outcome_q == OUT_STOR);
        fault_seg      = (outcome_q == OUT_SEG);
        fault_instr    = f_instr;
        fault_cause    = f_cause;
        fault_addr     = f_addr;
        walk_start     = (state_q == ST_REPORT) && (outcome_q == OUT_WALK);
        walk_ea        = ea_q;
        walk_acc       = acc_q;
        walk_pr        = pr_q;
        walk_lpid      = lpid_q;
        walk_pid       = pid_q;
        walk_root_base = EA_W'({root_q, 8'b0});
        walk_root_size = rsz_q;
        walk_as_size   = {1'b0, tsz_hi_q, tsz_lo_q} + AS_BIAS;
    end

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_valid, fault_valid, walk_start})); // R10
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy); // R10
    AST_BYPASS_FORM: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_raddr[EA_W-1 -: CLR_BITS] == '0 && res_perm == 3'b111)); // R3
    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R8
    AST_SEG_DATA_QUAD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && fault_seg && !fault_instr) |-> (fault_addr[EA_W-1] ^ fault_addr[EA_W-2])); // R5
    AST_FETCH_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && fault_instr) |-> (!fault_cause[CB_STORE] && fault_addr == '0)); // R7
    AST_WALK_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        walk_start |-> $past(mem_rsp_valid)); // R9
endmodule

// File: tb/xlat_front_end_tb.sv
module xlat_front_end_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        req_valid = 0, req_ready, req_pr = 0, req_ir = 0, req_dr = 0;
    logic [63:0] req_ea = 0;
    logic [1:0]  req_acc = 0;
    logic [11:0] cfg_lpid = 0;
    logic [19:0] cfg_pid = 0;
    logic [63:0] cfg_tbl_base = 0;
    logic [4:0]  cfg_tbl_log = 0;
    logic        busy, mem_req_valid, mem_req_ready = 0, mem_rsp_valid = 0;
    logic [63:0] mem_req_addr, mem_rsp_data = 0;
    logic        res_valid, fault_valid, fault_seg, fault_instr, walk_start, walk_pr;
    logic [63:0] res_raddr, fault_addr, walk_ea, walk_root_base;
    logic [2:0]  res_perm;
    logic [4:0]  fault_cause, walk_root_size;
    logic [1:0]  walk_acc;
    logic [11:0] walk_lpid;
    logic [19:0] walk_pid;
    logic [5:0]  walk_as_size;

    xlat_front_end dut_i (.*);

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual %0d expected below 100000", cyc);
                finish_run();
            end
        end
    end

    function automatic logic [63:0] exp_cause(input logic [1:0] acc, input bit seg);
        if (seg) return 64'd0;
        return (acc == 2'd1) ? 64'h11 : 64'h01;
    endfunction

    // One request end to end; poke holds a competing request while busy.
    task automatic run_req(input logic [63:0] ea, input logic [1:0] acc,
                           input bit pr, input bit ir, input bit dr,
                           input logic [11:0] lpid, input logic [19:0] pid,
                           input logic [63:0] base, input logic [4:0] tlog,
                           input bit poke);
        bit fetch = (acc == 2'd2);
        bit byp = fetch ? !ir : !dr;
        logic [1:0] q = ea[63:62];
        bit qbad = (q == 2'd1) || (q == 2'd2);
        logic [19:0] spid = (q == 2'd0) ? pid : 20'd0;
        bit oor = ((64'(spid) >> (tlog + 5'd8)) != 0);
        logic [63:0] ent = {$urandom, $urandom};
        @(negedge clk);
        req_valid = 1; req_ea = ea; req_acc = acc; req_pr = pr; req_ir = ir; req_dr = dr;
        cfg_lpid = lpid; cfg_pid = pid; cfg_tbl_base = base; cfg_tbl_log = tlog;
        chk(req_ready == 1, "R10", "ready when idle", 64'(req_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        req_valid = poke; req_ea = {$urandom, $urandom}; req_acc = 2'd0; req_dr = 0;
        cfg_pid = 20'($urandom); cfg_tbl_base = {$urandom, $urandom};
        chk(busy == 1, "R10", "busy after accept", 64'(busy), 64'd1);
        if (byp) begin
            chk(res_valid == 1, "R2", "bypass taken", 64'(res_valid), 64'd1);
            chk(res_raddr == (ea & 64'h0FFF_FFFF_FFFF_FFFF), "R3", "real address", res_raddr,
                ea & 64'h0FFF_FFFF_FFFF_FFFF);
            chk(res_perm == 3'b111, "R3", "permissions", 64'(res_perm), 64'd7);
            chk(!fault_valid && !walk_start && !mem_req_valid, "R10", "single outcome",
                64'({fault_valid, walk_start, mem_req_valid}), 64'd0);
        end else if (qbad || oor) begin
            chk(fault_valid == 1 && res_valid == 0, qbad ? "R5" : "R6", "fault raised",
                64'({fault_valid, res_valid}), 64'h2);
            chk(fault_seg == qbad, qbad ? "R5" : "R6", "fault kind", 64'(fault_seg), 64'(qbad));
            chk(fault_instr == fetch, "R7", "fault type", 64'(fault_instr), 64'(fetch));
            chk(64'(fault_cause) == exp_cause(acc, qbad), qbad ? "R5" : "R7", "cause",
                64'(fault_cause), exp_cause(acc, qbad));
            chk(fault_addr == (fetch ? 64'd0 : ea), "R7", "fault address", fault_addr,
                fetch ? 64'd0 : ea);
            chk(mem_req_valid == 0, "R6", "no table read", 64'(mem_req_valid), 64'd0);
        end else begin
            logic [63:0] a = base + (64'(spid) << 4);
            int stall = $urandom % 3;
            int dly = $urandom % 3;
            chk(mem_req_valid == 1 && res_valid == 0 && fault_valid == 0, "R2",
                "walk read started", 64'({mem_req_valid, res_valid, fault_valid}), 64'h4);
            chk(mem_req_addr == a, "R8", "entry address", mem_req_addr, a);
            for (int i = 0; i < stall; i++) begin
                @(posedge clk);
                @(negedge clk);
                chk(mem_req_valid == 1 && mem_req_addr == a, "R8", "request held",
                    mem_req_addr, a);
            end
            mem_req_ready = 1;
            @(posedge clk);
            @(negedge clk);
            mem_req_ready = 0;
            for (int i = 0; i < dly; i++) begin
                @(posedge clk);
                @(negedge clk);
                chk(busy && !walk_start && !res_valid && !fault_valid, "R10", "waiting",
                    64'({busy, walk_start, res_valid, fault_valid}), 64'h8);
            end
            mem_rsp_valid = 1; mem_rsp_data = ent;
            @(posedge clk);
            @(negedge clk);
            mem_rsp_valid = 0; mem_rsp_data = {$urandom, $urandom};
            req_valid = 0;
            chk(walk_start == 1 && res_valid == 0 && fault_valid == 0, "R9", "walk start",
                64'({walk_start, res_valid, fault_valid}), 64'h4);
            chk(walk_root_base == {ent[59:8], 8'b0}, "R9", "root base", walk_root_base,
                {ent[59:8], 8'b0});
            chk(walk_root_size == ent[4:0], "R9", "root size", 64'(walk_root_size), 64'(ent[4:0]));
            chk(64'(walk_as_size) == 64'({ent[62:61], ent[7:5]}) + 64'd31, "R9", "as size",
                64'(walk_as_size), 64'({ent[62:61], ent[7:5]}) + 64'd31);
            chk(walk_lpid == lpid && walk_pid == spid, "R4", "identifiers",
                64'({walk_lpid, walk_pid}), 64'({lpid, spid}));
            chk(walk_ea == ea && walk_acc == acc && walk_pr == pr, "R9", "request fields",
                walk_ea, ea);
        end
        req_valid = 0;
        @(posedge clk);
        @(negedge clk);
        chk(busy == 0 && req_ready == 1 && !res_valid && !fault_valid && !walk_start,
            "R10", "back to idle", 64'({busy, req_ready}), 64'h1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(req_ready == 1 && busy == 0 && !res_valid && !fault_valid && !walk_start
            && !mem_req_valid, "R1", "reset state",
            64'({req_ready, busy, res_valid, fault_valid, walk_start, mem_req_valid}), 64'h20);
        rst_n = 1;
        // R2: fetch with ir clear bypasses even with dr set
        run_req(64'hF234_5678_9ABC_DEF0, 2'd2, 0, 0, 1, 12'h5, 20'h3, 64'h1000, 5'd0, 0);
        // R2: fetch with ir set translates even with dr clear (quadrant 0 walk)
        run_req(64'h0000_0000_0040_0000, 2'd2, 1, 1, 0, 12'h7, 20'h12, 64'h8000, 5'd1, 0);
        // R2/R3: read with dr clear bypasses
        run_req(64'hA000_0000_0000_1234, 2'd0, 0, 1, 0, 12'h1, 20'h1, 64'h0, 5'd0, 0);
        // R5: fetch in quadrant 1, write in quadrant 2
        run_req(64'h4000_0000_0000_0100, 2'd2, 0, 1, 1, 12'h1, 20'h1, 64'h0, 5'd0, 0);
        run_req(64'h8000_0000_0000_0200, 2'd1, 0, 1, 1, 12'h1, 20'h1, 64'h0, 5'd0, 0);
        // R6: exact bound with log 0 faults (pid 256), one below walks
        run_req(64'h0000_0000_0000_0300, 2'd0, 0, 1, 1, 12'h2, 20'd256, 64'h4000, 5'd0, 0);
        run_req(64'h0000_0000_0000_0300, 2'd0, 0, 1, 1, 12'h2, 20'd255, 64'h4000, 5'd0, 0);
        // R7: write bound fault sets store flag; fetch bound fault is instruction type
        run_req(64'h0000_0000_0000_0400, 2'd1, 0, 1, 1, 12'h2, 20'hFFFFF, 64'h0, 5'd3, 0);
        run_req(64'h0000_0000_0000_0400, 2'd2, 0, 1, 1, 12'h2, 20'hFFFFF, 64'h0, 5'd3, 0);
        // R4: quadrant 3 uses pid 0, so a huge pid never faults
        run_req(64'hC000_0000_1234_5000, 2'd1, 1, 1, 1, 12'hABC, 20'hFFFFF, 64'h9000, 5'd0, 0);
        // R10: competing request held while busy is ignored
        run_req(64'h0000_0000_0000_0800, 2'd0, 0, 1, 1, 12'h3, 20'h4, 64'h2000, 5'd2, 1);
        for (int n = 0; n < 150; n++) begin
            logic [63:0] ea = {$urandom, $urandom};
            run_req(ea, 2'($urandom % 4), 1'($urandom), ($urandom % 4) != 0,
                    ($urandom % 4) != 0, 12'($urandom), 20'($urandom % 2048),
                    {$urandom, $urandom}, 5'($urandom % 4), 1'($urandom));
        end
        finish_run();
    end
endmodule